// File: doc/BRIEF.md
# Character Display Instruction Executor

This block is the controller side of a character display module attached to an 8-bit parallel host bus. Each bus access is taken on the falling edge of an enable strobe. Two select lines, a register-select and a read/write line, steer the access to one of four places: the instruction path, the status read, a RAM data write or a RAM data read. Instructions are decoded by the position of their highest set bit. They update the display settings, load or move a 7-bit address counter, pick the RAM that data accesses target, clear the display memory or return the cursor home.

Every accepted instruction or RAM access starts a busy period that stands in for its execution time. The period is counted in ticks of a slow internal clock, which is made by dividing the system clock. The host polls the busy bit through the status read, and that read is always served at once. The display data memory (128 bytes) and the character-generator memory (64 bytes) are internal arrays. After each data access the address counter steps up or down by one.

Top module: `chardisp_exec`

## Requirements
- R1: An access takes effect on the clock edge where the enable strobe is seen falling. {bus_rs,bus_rw} selects the target: 00 is an instruction write, 01 is a status read, 10 is a RAM data write and 11 is a RAM data read. For the two reads, bus_dout presents the data while the strobe is high.
- R2: The status read returns the busy flag on bit 7 and the address counter on bits 6..0. It never starts a busy period and never changes any state.
- R3: The instruction is chosen by its highest set bit. Bit 0 is clear, bit 1 is home, bit 2 is entry mode, bit 3 is display control, bit 4 is shift, bit 5 is function set, bit 6 sets the CGRAM address and bit 7 sets the DDRAM address. Bits below the field an instruction uses are ignored. The code 0x00 does nothing and does not make the block busy.
- R4: Clear writes 0x20 into every DDRAM byte, zeroes the address counter and the display offset, and selects DDRAM.
- R5: Home zeroes the address counter and the display offset and selects DDRAM. It leaves DDRAM contents unchanged.
- R6: Busy lasts exactly ticks × CLK_DIV system cycles from the accepting edge. The tick count is T_LONG for clear and home, T_SHORT for the other instructions and T_RAM for data accesses.
- R7: After each accepted RAM read or write, the address counter steps by +1 when entry bit 1 (I/D) is 1 and by −1 when it is 0. It wraps modulo 128.
- R8: When entry bit 0 (SH) is set, each DDRAM write also moves disp_shift, by −1 when I/D=1 and by +1 when I/D=0.
- R9: In the shift instruction, bit 3 chooses the display (1) or the cursor (0), and bit 2 gives the direction, right (+1) or left (−1). A display shift moves disp_shift and a cursor shift moves the address counter. RAM is never changed.
- R10: Display control latches disp_on, cur_on and blink_on from bits 2, 1 and 0. Function set latches bus8, lines2 and font_tall from bits 4, 3 and 2.
- R11: The CGRAM address instruction loads the counter with bits 5..0 and sends later data accesses to CGRAM, which is indexed by counter bits 5..0. The DDRAM address instruction loads bits 6..0 and sends later data accesses to DDRAM.
- R12: While busy, writes of either kind are ignored and set wr_err, which stays set until reset. RAM reads while busy do not step the counter.
- R13: After reset the counter, busy, offset, wr_err and the three display bits are 0, bus8 is 1, and I/D is 1 with SH at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_en | input | 1 | Enable strobe; its falling edge commits the access |
| bus_rs | input | 1 | Register select: 0 instruction/status, 1 RAM data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_din | input | 8 | Write data from the host |
| bus_dout | output | 8 | Read data to the host |
| wr_err | output | 1 | Sticky flag: a write arrived while busy |
| disp_on | output | 1 | Display enabled |
| cur_on | output | 1 | Cursor shown |
| blink_on | output | 1 | Cursor blink |
| bus8 | output | 1 | Data length setting (1 = 8-bit) |
| lines2 | output | 1 | Two-line setting |
| font_tall | output | 1 | Tall font setting |
| disp_shift | output | SHIFT_W | Display offset, two's complement |

## Verification
Instruction bytes are chosen so that each decode path is hit once with only its leading bit and its fields set, and once with extra low-order bits set, for example 0x03 and 0x3F. This shows that decoding goes by the highest set bit and not by exact match. Data accesses run with I/D set to 1 and to 0, one of them across address 0, so that counter increment, decrement and wrap can each be seen alone. The same byte is written to DDRAM and to CGRAM at overlapping addresses to show that the RAM target is selected. Busy windows are timed cycle by cycle for each of the three duration classes. Writes are placed inside a clear's busy window to separate rejected accesses from accepted ones.

// File: rtl/chardisp_pkg.sv
`timescale 1ns/1ps
package chardisp_pkg;
   typedef enum logic [3:0] {
      OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP,
      OP_SHIFT, OP_FUNC, OP_CGADDR, OP_DDADDR
   } op_e;

   // {register select, read/write}
   typedef enum logic [1:0] {
      ACC_CMD  = 2'b00,
      ACC_STAT = 2'b01,
      ACC_WDAT = 2'b10,
      ACC_RDAT = 2'b11
   } acc_e;

   localparam logic [7:0] BLANK_CODE = 8'h20;
endpackage

// File: rtl/chardisp_decode.sv
`timescale 1ns/1ps
module chardisp_decode
   import chardisp_pkg::*;
(
   input  logic [7:0] cmd,
   output op_e        op
);
   logic [3:0] lead;

   always_comb begin
      lead = 4'd8;
      for (int i = 0; i < 8; i++) begin
         if (cmd[i]) lead = 4'(i);
      end
      unique case (lead)
         4'd0:    op = OP_CLEAR;
         4'd1:    op = OP_HOME;
         4'd2:    op = OP_ENTRY;
         4'd3:    op = OP_DISP;
         4'd4:    op = OP_SHIFT;
         4'd5:    op = OP_FUNC;
         4'd6:    op = OP_CGADDR;
         4'd7:    op = OP_DDADDR;
         default: op = OP_NONE;
      endcase
   end
endmodule

// File: rtl/chardisp_timer.sv
`timescale 1ns/1ps
module chardisp_timer #(
   parameter int CLK_DIV = 185,
   parameter int CNT_W   = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] load,
   output logic             busy
);
   logic             tick;
   logic [CNT_W-1:0] remain;

   generate
      if (CLK_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(CLK_DIV);
         localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);
         logic [DW-1:0] phase;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     phase <= '0;
            else if (start || phase == LAST) phase <= '0;
            else                             phase <= phase + DW'(1);
         end
         assign tick = (phase == LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        remain <= '0;
      else if (start)                    remain <= load;
      else if (tick && remain != '0)     remain <= remain - CNT_W'(1);
   end

   assign busy = (remain != '0);
endmodule

// File: rtl/chardisp_ram.sv
`timescale 1ns/1ps
module chardisp_ram #(
   parameter int         AW   = 7,
   parameter logic [7:0] FILL = 8'h20
) (
   input  logic          clk,
   input  logic          we,
   input  logic          fill,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   localparam int DEPTH = 1 << AW;
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (fill) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= FILL;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/chardisp_exec.sv
`timescale 1ns/1ps
module chardisp_exec
   import chardisp_pkg::*;
#(
   parameter int CLK_DIV = 185,
   parameter int T_LONG  = 413,
   parameter int T_SHORT = 11,
   parameter int T_RAM   = 12,
   parameter int AC_W    = 7,
   parameter int CG_AW   = 6,
   parameter int SHIFT_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_en,
   input  logic               bus_rs,
   input  logic               bus_rw,
   input  logic [7:0]         bus_din,
   output logic [7:0]         bus_dout,
   output logic               wr_err,
   output logic               disp_on,
   output logic               cur_on,
   output logic               blink_on,
   output logic               bus8,
   output logic               lines2,
   output logic               font_tall,
   output logic [SHIFT_W-1:0] disp_shift
);
   localparam int T_MAX0 = (T_LONG > T_SHORT) ? T_LONG : T_SHORT;
   localparam int T_MAX  = (T_MAX0 > T_RAM) ? T_MAX0 : T_RAM;
   localparam int CNT_W  = $clog2(T_MAX + 1);
   localparam logic [AC_W-1:0]    AC_ONE = AC_W'(1);
   localparam logic [SHIFT_W-1:0] SH_ONE = SHIFT_W'(1);

   if (AC_W < 1 || AC_W > 7) begin : g_bad_ac
      $error("AC_W must be 1..7");
   end
   if (CG_AW < 1 || CG_AW > 6 || CG_AW > AC_W) begin : g_bad_cg
      $error("CG_AW must be 1..6 and no wider than AC_W");
   end
   if (CLK_DIV < 1 || T_LONG < 1 || T_SHORT < 1 || T_RAM < 1) begin : g_bad_t
      $error("divider and tick counts must be positive");
   end

   logic             en_q, acc_fall, busy;
   logic             cmd_go, dat_go, wr_rej, fill_go;
   logic [CNT_W-1:0] t_load;
   acc_e             acc;
   op_e              op;
   logic [AC_W-1:0]  ac_q;
   logic             sel_cg, inc_q, shen_q;
   logic [7:0]       dd_rd, cg_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= bus_en;
   end

   assign acc_fall = en_q & ~bus_en;
   assign acc      = acc_e'({bus_rs, bus_rw});
   assign cmd_go   = acc_fall && !busy && acc == ACC_CMD && op != OP_NONE;
   assign dat_go   = acc_fall && !busy && (acc == ACC_WDAT || acc == ACC_RDAT);
   assign wr_rej   = acc_fall && busy && !bus_rw;
   assign fill_go  = cmd_go && op == OP_CLEAR;

   chardisp_decode u_dec (.cmd(bus_din), .op(op));

   always_comb begin
      if (dat_go)                                t_load = CNT_W'(T_RAM);
      else if (op == OP_CLEAR || op == OP_HOME)  t_load = CNT_W'(T_LONG);
      else                                       t_load = CNT_W'(T_SHORT);
   end

   chardisp_timer #(.CLK_DIV(CLK_DIV), .CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(cmd_go || dat_go),
      .load(t_load), .busy(busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ac_q <= '0;  sel_cg <= 1'b0; inc_q <= 1'b1; shen_q <= 1'b0;
         disp_on <= 1'b0; cur_on <= 1'b0; blink_on <= 1'b0;
         bus8 <= 1'b1; lines2 <= 1'b0; font_tall <= 1'b0;
         disp_shift <= '0; wr_err <= 1'b0;
      end else begin
         if (wr_rej) wr_err <= 1'b1;
         if (cmd_go) begin
            unique case (op)
               OP_CLEAR, OP_HOME: begin
                  ac_q <= '0; disp_shift <= '0; sel_cg <= 1'b0;
               end
               OP_ENTRY: begin
                  inc_q <= bus_din[1]; shen_q <= bus_din[0];
               end
               OP_DISP: begin
                  disp_on <= bus_din[2]; cur_on <= bus_din[1]; blink_on <= bus_din[0];
               end
               OP_SHIFT: begin
                  if (bus_din[3])
                     disp_shift <= bus_din[2] ? disp_shift + SH_ONE : disp_shift - SH_ONE;
                  else
                     ac_q <= bus_din[2] ? ac_q + AC_ONE : ac_q - AC_ONE;
               end
               OP_FUNC: begin
                  bus8 <= bus_din[4]; lines2 <= bus_din[3]; font_tall <= bus_din[2];
               end
               OP_CGADDR: begin
                  ac_q <= AC_W'(bus_din[CG_AW-1:0]); sel_cg <= 1'b1;
               end
               OP_DDADDR: begin
                  ac_q <= bus_din[AC_W-1:0]; sel_cg <= 1'b0;
               end
               default: ;
            endcase
         end
         if (dat_go) begin
            ac_q <= inc_q ? ac_q + AC_ONE : ac_q - AC_ONE;
            if (acc == ACC_WDAT && !sel_cg && shen_q)
               disp_shift <= inc_q ? disp_shift - SH_ONE : disp_shift + SH_ONE;
         end
      end
   end

   chardisp_ram #(.AW(AC_W), .FILL(BLANK_CODE)) u_ddram (
      .clk(clk), .we(dat_go && acc == ACC_WDAT && !sel_cg), .fill(fill_go),
      .waddr(ac_q), .wdata(bus_din), .raddr(ac_q), .rdata(dd_rd)
   );

   chardisp_ram #(.AW(CG_AW), .FILL(8'h00)) u_cgram (
      .clk(clk), .we(dat_go && acc == ACC_WDAT && sel_cg), .fill(1'b0),
      .waddr(ac_q[CG_AW-1:0]), .wdata(bus_din), .raddr(ac_q[CG_AW-1:0]),
      .rdata(cg_rd)
   );

   always_comb begin
      unique case (acc)
         ACC_STAT: bus_dout = {busy, 7'(ac_q)};
         ACC_RDAT: bus_dout = sel_cg ? cg_rd : dd_rd;
         default:  bus_dout = 8'h00;
      endcase
   end
endmodule

// File: rtl/chardisp_exec_chk.sv
`timescale 1ns/1ps
module chardisp_exec_chk #(
   parameter int AC_W = 7
) (
   input logic            clk,
   input logic            rst_n,
   input logic            fall,
   input logic            busy,
   input logic            bus_rs,
   input logic            bus_rw,
   input logic [7:0]      bus_din,
   input logic [7:0]      bus_dout,
   input logic [AC_W-1:0] ac,
   input logic            inc,
   input logic            wr_err
);
   a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |=> wr_err);

   a_r12_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && busy && !bus_rw) |=> $stable(ac));

   a_r6_cmd_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !busy && !bus_rs && !bus_rw && bus_din != 8'h00) |=> busy);

   a_r2_status_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !busy && !bus_rs && bus_rw) |=> !busy);

   a_r2_status_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rs && bus_rw) |-> (bus_dout[7] == busy));

   a_r7_ac_step: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !busy && bus_rs) |=>
         (ac == ($past(inc) ? $past(ac) + AC_W'(1) : $past(ac) - AC_W'(1))));

   a_r5_home_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !busy && !bus_rs && !bus_rw && bus_din[7:1] == 7'b0000001) |=> (ac == '0));
endmodule

bind chardisp_exec chardisp_exec_chk #(.AC_W(AC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .fall(acc_fall), .busy(busy),
   .bus_rs(bus_rs), .bus_rw(bus_rw), .bus_din(bus_din), .bus_dout(bus_dout),
   .ac(ac_q), .inc(inc_q), .wr_err(wr_err)
);

// File: tb/sim_chardisp_exec.sv
`timescale 1ns/1ps
module sim_chardisp_exec;
   localparam int DIV = 2, TL = 20, TS = 4, TR = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_en = 1'b0, bus_rs = 1'b0, bus_rw = 1'b0;
   logic [7:0] bus_din = 8'h00;
   logic [7:0] bus_dout;
   logic wr_err, disp_on, cur_on, blink_on, bus8, lines2, font_tall;
   logic [6:0] disp_shift;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   chardisp_exec #(.CLK_DIV(DIV), .T_LONG(TL), .T_SHORT(TS), .T_RAM(TR)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_rs(bus_rs), .bus_rw(bus_rw),
      .bus_din(bus_din), .bus_dout(bus_dout), .wr_err(wr_err), .disp_on(disp_on),
      .cur_on(cur_on), .blink_on(blink_on), .bus8(bus8), .lines2(lines2),
      .font_tall(font_tall), .disp_shift(disp_shift)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_cycle(input logic rs, input logic rw, input logic [7:0] d,
                            output logic [7:0] q);
      @(negedge clk);
      bus_rs = rs; bus_rw = rw; bus_din = d; bus_en = 1'b1;
      @(negedge clk);
      #1 q = bus_dout;
      bus_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic stat(output logic [7:0] q);
      bus_cycle(1'b0, 1'b1, 8'h00, q);
   endtask

   task automatic wait_idle();
      logic [7:0] q;
      for (int i = 0; i < 400; i++) begin
         stat(q);
         if (!q[7]) break;
      end
   endtask

   task automatic cmd(input logic [7:0] d);
      logic [7:0] q;
      bus_cycle(1'b0, 1'b0, d, q); wait_idle();
   endtask

   task automatic wdat(input logic [7:0] d);
      logic [7:0] q;
      bus_cycle(1'b1, 1'b0, d, q); wait_idle();
   endtask

   task automatic rdat(output logic [7:0] q);
      bus_cycle(1'b1, 1'b1, 8'h00, q); wait_idle();
   endtask

   task automatic timed(input logic rs, input logic rw, input logic [7:0] d, output int n);
      logic [7:0] q;
      bus_cycle(rs, rw, d, q);
      bus_rs = 1'b0; bus_rw = 1'b1; bus_en = 1'b1;
      #1 n = 0;
      while (bus_dout[7] && n < 2000) begin
         n++;
         @(negedge clk); #1;
      end
      @(negedge clk); bus_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] q;
      stat(q);
      chk("R13 status after reset", q, 8'h00);
      chk("R13 display bits", {disp_on, cur_on, blink_on}, 0);
      chk("R13 function bits", {bus8, lines2, font_tall}, 3'b100);
      chk("R13 offset and err", {disp_shift, wr_err}, 0);
   endtask

   task automatic t_clear();
      int n, bad;
      logic [7:0] q;
      timed(1'b0, 1'b0, 8'h01, n);
      chk("R6 R4 clear busy cycles", n, TL * DIV);
      timed(1'b0, 1'b0, 8'h80, n);
      chk("R6 short busy cycles", n, TS * DIV);
      bad = 0;
      for (int a = 0; a < 128; a++) begin
         rdat(q);
         if (q != 8'h20) bad++;
      end
      chk("R4 DDRAM blank count of mismatches", bad, 0);
      stat(q);
      chk("R7 counter wrapped after 128 reads", q, 8'h00);
   endtask

   task automatic t_write_read();
      int n;
      logic [7:0] q;
      cmd(8'h85);
      timed(1'b1, 1'b0, 8'h41, n);
      chk("R6 RAM busy cycles", n, TR * DIV);
      wdat(8'h42); wdat(8'h43);
      stat(q);
      chk("R7 counter after three writes", q, 8'h08);
      cmd(8'h85);
      rdat(q); chk("R1 read data 0", q, 8'h41);
      rdat(q); chk("R1 read data 1", q, 8'h42);
      rdat(q); chk("R1 read data 2", q, 8'h43);
   endtask

   task automatic t_decrement();
      logic [7:0] q;
      cmd(8'h04);
      cmd(8'h90); wdat(8'h11);
      stat(q); chk("R7 decrement", q, 8'h0F);
      cmd(8'h80); wdat(8'h12);
      stat(q); chk("R7 wrap below zero", q, 8'h7F);
      cmd(8'h06);
   endtask

   task automatic t_entry_shift();
      cmd(8'h07);
      cmd(8'hA0); wdat(8'h55);
      chk("R8 shift with I/D=1", disp_shift, 7'h7F);
      cmd(8'h05); wdat(8'h56);
      chk("R8 shift with I/D=0", disp_shift, 0);
      cmd(8'h06);
   endtask

   task automatic t_cursor_shift();
      logic [7:0] q;
      cmd(8'h90); wdat(8'h77);
      cmd(8'h90);
      cmd(8'h14);
      stat(q); chk("R9 cursor right", q, 8'h11);
      cmd(8'h10); cmd(8'h10);
      stat(q); chk("R9 cursor left", q, 8'h0F);
      chk("R9 cursor shift leaves offset", disp_shift, 0);
      cmd(8'h90); rdat(q);
      chk("R9 RAM unchanged by shift", q, 8'h77);
   endtask

   task automatic t_home();
      int n;
      logic [7:0] q;
      cmd(8'hB3);
      cmd(8'h1C);
      chk("R9 display right", disp_shift, 1);
      timed(1'b0, 1'b0, 8'h02, n);
      chk("R6 home busy cycles", n, TL * DIV);
      stat(q); chk("R5 home counter", q, 8'h00);
      chk("R5 home offset", disp_shift, 0);
      cmd(8'h85); rdat(q);
      chk("R5 DDRAM kept", q, 8'h41);
   endtask

   task automatic t_disp_func();
      cmd(8'h0F);
      chk("R10 display all on", {disp_on, cur_on, blink_on}, 3'b111);
      cmd(8'h0C);
      chk("R10 display only", {disp_on, cur_on, blink_on}, 3'b100);
      cmd(8'h38);
      chk("R10 function 8bit 2line", {bus8, lines2, font_tall}, 3'b110);
      cmd(8'h24);
      chk("R10 function 4bit tall", {bus8, lines2, font_tall}, 3'b001);
   endtask

   task automatic t_decode();
      int n;
      logic [7:0] q;
      cmd(8'h8A);
      timed(1'b0, 1'b0, 8'h00, n);
      chk("R3 zero code not busy", n, 0);
      stat(q); chk("R3 zero code no change", q, 8'h0A);
      cmd(8'h03);
      stat(q); chk("R3 0x03 acts as home", q, 8'h00);
      cmd(8'h3F);
      chk("R3 0x3F acts as function set", {bus8, lines2, font_tall}, 3'b111);
      cmd(8'h0A);
      chk("R3 0x0A acts as display control", {disp_on, cur_on, blink_on}, 3'b010);
   endtask

   task automatic t_cgram();
      logic [7:0] q;
      cmd(8'h01);
      cmd(8'h43);
      stat(q); chk("R11 CGRAM address load", q, 8'h03);
      wdat(8'h15);
      stat(q); chk("R11 CGRAM counter step", q, 8'h04);
      cmd(8'h83); rdat(q);
      chk("R11 DDRAM untouched by CGRAM write", q, 8'h20);
      cmd(8'h43); rdat(q);
      chk("R11 CGRAM readback", q, 8'h15);
   endtask

   task automatic t_busy_reject();
      logic [7:0] q;
      cmd(8'h0F);
      chk("R12 no error yet", wr_err, 0);
      bus_cycle(1'b0, 1'b0, 8'h01, q);
      bus_cycle(1'b1, 1'b0, 8'h99, q);
      bus_cycle(1'b0, 1'b0, 8'h08, q);
      chk("R12 error raised", wr_err, 1);
      wait_idle();
      chk("R12 instruction while busy ignored", disp_on, 1);
      stat(q); chk("R12 counter after rejected data", q, 8'h00);
      rdat(q); chk("R12 RAM not written while busy", q, 8'h20);
      cmd(8'h80);
      chk("R12 error sticky", wr_err, 1);
   endtask

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_clear();
      t_write_read();
      t_decrement();
      t_entry_shift();
      t_cursor_shift();
      t_home();
      t_disp_func();
      t_decode();
      t_cgram();
      t_busy_reject();
      done = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not complete");
         report();
         $finish;
      end
   end
endmodule